// File: doc/BRIEF.md
# Commanded Status Proof Checker

This block watches a one-bit command sent to a piece of equipment and the one-bit status fed back from it. It decides whether the feedback agrees with the command, and raises one of two alarm flags when it does not. One flag, `stuck_low_o`, means the command is high but the feedback stays low. The other, `stuck_high_o`, means the command is low but the feedback stays high. When both flags are high together, the feedback is still moving and cannot be trusted.

Time is counted in cycles of one synchronous clock, and the block has a synchronous reset. Two restartable down-counters set the timing:

- **Command timer.** Reloads whenever the command changes, with a length of `fb_delay_i + debounce_i` cycles.
- **Feedback timer.** Reloads whenever the feedback changes, with a length of `debounce_i` cycles.

The feedback counts as stable once its timer has run out. After a command change, checking starts again when the first of two events occurs:

- the command timer runs out; or
- the feedback moves after that command change and then settles.

A small state machine holds the verdict. Its states are:

- `PS_WAIT`: not yet checking.
- `PS_UNSTABLE`: the feedback is still moving.
- `PS_MATCH`: the feedback agrees with the command.
- `PS_LOCK_LOW`: the command is high and the feedback is low.
- `PS_LOCK_HIGH`: the command is low and the feedback is high.

Its transitions are:

- A command change sends any state to `PS_WAIT`.
- `PS_WAIT` moves to a verdict state when checking starts.
- Each verdict state re-evaluates every cycle and moves to `PS_UNSTABLE`, `PS_MATCH`, `PS_LOCK_LOW` or `PS_LOCK_HIGH`.

Reset enters `PS_WAIT` and starts both timers, as if both inputs had just changed. The flags are decoded from the state alone.

Top module: `proof_checker`

## Requirements
- R1: A command change reloads the command timer with `fb_delay_i + debounce_i`. If the feedback does not move after that change, checking starts at the clock edge that lies `fb_delay_i + debounce_i + 1` edges after the edge that first sampled the change.
- R2: A feedback change reloads the feedback timer with `debounce_i`. The feedback is stable from the edge that lies `debounce_i + 1` edges after the edge that first sampled the change, provided it has not changed again.
- R3: In `PS_WAIT`, checking also starts as soon as the feedback has changed since the last command change and is then stable. This happens even when that is earlier than the command timer.
- R4: While checking, if the feedback is not stable (its timer is running, or it changes in that cycle), both flags are high.
- R5: While checking, if the feedback is stable and equal to the command, both flags are low.
- R6: While checking, if the feedback is stable, the command is 1 and the feedback is 0, then `stuck_low_o`=1 and `stuck_high_o`=0.
- R7: While checking, if the feedback is stable, the command is 0 and the feedback is 1, then `stuck_low_o`=0 and `stuck_high_o`=1.
- R8: The edge that samples a command change puts the block into `PS_WAIT`, with both flags low.
- R9: During reset and after it, until checking starts, both flags are low. Reset restarts both timers and creates no false edge.
- R10: With both durations zero, a change gives its verdict one edge after the edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 1 | Command bit sent to the equipment |
| fb_i | input | 1 | Status bit fed back by the equipment |
| fb_delay_i | input | DUR_W | Allowed response delay, in cycles |
| debounce_i | input | DUR_W | Cycles the feedback must hold to count as stable |
| stuck_low_o | output | 1 | Feedback low while the command is high (with `stuck_high_o`: unstable) |
| stuck_high_o | output | 1 | Feedback high while the command is low (with `stuck_low_o`: unstable) |

## Verification
The bench aims at the exact cycle in which each timer runs out. A counter off by one would show its verdict one cycle early or one cycle late.

A feedback that moves briefly after a command change and then settles must end the wait before the command timer does. A design that only uses the command timer gives the stuck-high verdict one cycle too late.

A feedback that toggles through the whole command window must give both flags high once that window ends. A design that compares the raw bits would report a plain mismatch instead.

Zero durations and a reset applied while an alarm is active check that no false edge or stale verdict survives.

// File: rtl/proof_pkg.sv
package proof_pkg;

    typedef enum logic [2:0] {
        PS_WAIT      = 3'd0,
        PS_UNSTABLE  = 3'd1,
        PS_MATCH     = 3'd2,
        PS_LOCK_LOW  = 3'd3,
        PS_LOCK_HIGH = 3'd4
    } proof_state_e;

endpackage

// File: rtl/proof_edge.sv
module proof_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic chg
);

    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= din;
    end

    assign chg = !rst && (din != prev_q);

    AST_EDGE_VS_PAST: assert property (@(posedge clk) disable iff (rst)
        chg == (din != $past(din)));  // R9

endmodule

// File: rtl/proof_timer.sv
module proof_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CW-1:0] len,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt_q == $past(len));  // R1

    AST_TMR_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!restart && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);  // R2

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!restart && done) |=> done);  // R2

endmodule

// File: rtl/proof_fsm.sv
module proof_fsm
    import proof_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    input  logic fb,
    input  logic cmd_chg,
    input  logic fb_chg,
    input  logic cmd_done,
    input  logic fb_done,
    output logic stuck_low,
    output logic stuck_high
);

    proof_state_e state_q, state_d, verdict;
    logic         fb_seen_q;
    logic         fb_stable;
    logic         start_check;

    assign fb_stable   = fb_done && !fb_chg;
    assign start_check = cmd_done || (fb_stable && fb_seen_q);

    always_comb begin
        if (!fb_stable) begin
            verdict = PS_UNSTABLE;
        end else if (cmd == fb) begin
            verdict = PS_MATCH;
        end else if (cmd) begin
            verdict = PS_LOCK_LOW;
        end else begin
            verdict = PS_LOCK_HIGH;
        end
    end

    always_comb begin
        state_d = state_q;
        if (cmd_chg) begin
            state_d = PS_WAIT;
        end else begin
            unique case (state_q)
                PS_WAIT:      state_d = start_check ? verdict : PS_WAIT;
                PS_UNSTABLE:  state_d = verdict;
                PS_MATCH:     state_d = verdict;
                PS_LOCK_LOW:  state_d = verdict;
                PS_LOCK_HIGH: state_d = verdict;
                default:      state_d = PS_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_WAIT;
            fb_seen_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (cmd_chg) begin
                fb_seen_q <= fb_chg;
            end else if (fb_chg) begin
                fb_seen_q <= 1'b1;
            end
        end
    end

    always_comb begin
        stuck_low  = 1'b0;
        stuck_high = 1'b0;
        unique case (state_q)
            PS_UNSTABLE:  begin stuck_low = 1'b1; stuck_high = 1'b1; end
            PS_LOCK_LOW:  stuck_low  = 1'b1;
            PS_LOCK_HIGH: stuck_high = 1'b1;
            default:      ;
        endcase
    end

    AST_CMD_CHG_WAITS: assert property (@(posedge clk) disable iff (rst)
        cmd_chg |=> (!stuck_low && !stuck_high));  // R8

    AST_FB_MOVE_UNSTABLE: assert property (@(posedge clk) disable iff (rst)
        (fb_chg && !cmd_chg && state_q != PS_WAIT) |=> (stuck_low && stuck_high));  // R4

    AST_STABLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_WAIT && !cmd_chg && !fb_chg && fb_done && cmd == fb)
        |=> (!stuck_low && !stuck_high));  // R5

    AST_LOCK_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_WAIT && !cmd_chg && !fb_chg && fb_done && cmd && !fb)
        |=> (stuck_low && !stuck_high));  // R6

    AST_LOCK_HIGH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_WAIT && !cmd_chg && !fb_chg && fb_done && !cmd && fb)
        |=> (!stuck_low && stuck_high));  // R7

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_WAIT && !cmd_done && !fb_done) |=> (!stuck_low && !stuck_high));  // R3

endmodule

// File: rtl/proof_checker.sv
module proof_checker #(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_i,
    input  logic             fb_i,
    input  logic [DUR_W-1:0] fb_delay_i,
    input  logic [DUR_W-1:0] debounce_i,
    output logic             stuck_low_o,
    output logic             stuck_high_o
);

    localparam int SUM_W = DUR_W + 1;

    logic             cmd_chg, fb_chg;
    logic             cmd_done, fb_done;
    logic [SUM_W-1:0] cmd_len;

    assign cmd_len = {1'b0, fb_delay_i} + {1'b0, debounce_i};

    proof_edge u_cmd_edge (
        .clk (clk),
        .rst (rst),
        .din (cmd_i),
        .chg (cmd_chg)
    );

    proof_edge u_fb_edge (
        .clk (clk),
        .rst (rst),
        .din (fb_i),
        .chg (fb_chg)
    );

    proof_timer #(.CW(SUM_W)) u_cmd_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (cmd_chg),
        .len     (cmd_len),
        .done    (cmd_done)
    );

    proof_timer #(.CW(DUR_W)) u_fb_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (fb_chg),
        .len     (debounce_i),
        .done    (fb_done)
    );

    proof_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd_i),
        .fb         (fb_i),
        .cmd_chg    (cmd_chg),
        .fb_chg     (fb_chg),
        .cmd_done   (cmd_done),
        .fb_done    (fb_done),
        .stuck_low  (stuck_low_o),
        .stuck_high (stuck_high_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!stuck_low_o && !stuck_high_o));  // R9

endmodule

// File: tb/proof_checker_bench.sv
module proof_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DUR_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd = 1'b1;
    logic             fb  = 1'b0;
    logic [DUR_W-1:0] dly = 8'd3;
    logic [DUR_W-1:0] deb = 8'd2;
    logic             s_low, s_high;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    proof_checker #(.DUR_W(DUR_W)) u_proof_checker (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .fb_i         (fb),
        .fb_delay_i   (dly),
        .debounce_i   (deb),
        .stuck_low_o  (s_low),
        .stuck_high_o (s_high)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic exp_low, input logic exp_high);
        checks++;
        if (s_low !== exp_low || s_high !== exp_high) begin
            errors++;
            $display("FAIL %s: low=%0b high=%0b expected low=%0b high=%0b",
                     tag, s_low, s_high, exp_low, exp_high);
        end
    endtask

    task automatic test_reset();
        cyc(2);
        check("R9 flags low in reset", 1'b0, 1'b0);
        rst = 1'b0;
        cyc(2);
        check("R9 no verdict before feedback timer", 1'b0, 1'b0);
        cyc(1);
        check("R6 stuck low after reset settle", 1'b1, 1'b0);
    endtask

    task automatic test_fb_follows();
        fb = 1'b1;
        cyc(1);
        check("R4 feedback moved", 1'b1, 1'b1);
        cyc(2);
        check("R2 still debouncing", 1'b1, 1'b1);
        cyc(1);
        check("R5 stable match", 1'b0, 1'b0);
    endtask

    task automatic test_early_fb_path();
        cmd = 1'b0;
        cyc(1);
        check("R8 command change waits", 1'b0, 1'b0);
        fb = 1'b0;
        cyc(1);
        fb = 1'b1;
        cyc(3);
        check("R3 waiting before feedback settles", 1'b0, 1'b0);
        cyc(1);
        check("R3 R7 early verdict stuck high", 1'b0, 1'b1);
    endtask

    task automatic test_cmd_path_unstable();
        cmd = 1'b1;
        for (int i = 0; i < 8; i++) begin
            fb = ~fb;
            cyc(1);
            if (i >= 6) check("R1 R4 command window ends unstable", 1'b1, 1'b1);
            else        check("R1 waiting for command timer", 1'b0, 1'b0);
        end
        cyc(2);
        check("R4 settling after toggles", 1'b1, 1'b1);
        cyc(1);
        check("R5 match after settle", 1'b0, 1'b0);
    endtask

    task automatic test_zero_durations();
        dly = '0;
        deb = '0;
        cmd = 1'b0;
        cyc(1);
        check("R8 R10 wait after change", 1'b0, 1'b0);
        cyc(1);
        check("R10 R7 immediate verdict", 1'b0, 1'b1);
        fb = 1'b0;
        cyc(1);
        check("R10 R4 unstable one cycle", 1'b1, 1'b1);
        cyc(1);
        check("R10 R5 match next cycle", 1'b0, 1'b0);
        fb = 1'b1;
        cyc(2);
        check("R10 R7 mismatch again", 1'b0, 1'b1);
        rst = 1'b1;
        cyc(1);
        check("R9 reset clears alarm", 1'b0, 1'b0);
        rst = 1'b0;
        cyc(1);
        check("R9 R10 verdict after reset", 1'b0, 1'b1);
    endtask

    initial begin
        cyc(1);
        test_reset();
        test_fb_follows();
        test_early_fb_path();
        test_cmd_path_unstable();
        test_zero_durations();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule